// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of a packet controller from a ring of buffer descriptors in memory. Software fills descriptors, marks them ready and then writes the transmit-active register. The engine reads descriptors one after another from its current ring position. For each one it streams the referenced buffer out one byte at a time. It writes the descriptor back with the ready bit cleared and moves to the next slot. The walk stops at the first descriptor that is not ready.

A frame can span any number of descriptors. A flag in the descriptor marks the one that closes the frame, and a second flag sends the walk back to the ring base. The bytes gathered into one frame are capped at 2032; anything past the cap is dropped and reported. The ring position is kept between activations, so each trigger resumes exactly where the previous walk stopped. The block masters a simple word-wide memory port with a request/acknowledge pair. It reports progress with single-cycle event pulses.

Top module: `txbd_ring_engine`

## Requirements
- R1: A descriptor is two 32-bit words at the current pointer. The first word holds flags in bits 31:16 and length in bits 15:0. The second word (pointer + 4) holds the buffer byte address. Bytes are big-endian within a word, so the byte at offset 0 sits in bits 31:24.
- R2: After reset, busy, mem_req, fo_valid and all event outputs are low. A kick while ctrl_en is high starts a walk. A kick while ctrl_en is low is ignored: busy stays low and no memory access is made.
- R3: When a fetched descriptor has flag bit 15 (ready) clear, the walk ends. No buffer read and no write-back happen for it, and the pointer stays on that descriptor.
- R4: The buffer bytes of a ready descriptor appear on fo_byte with fo_valid, one per pulse, in ascending address order, starting at any byte alignment.
- R5: The bytes of one frame are limited to 2032. A descriptor whose length exceeds the remaining room contributes only the remaining room, and ev_babt pulses at its write-back.
- R6: A descriptor with flag bit 11 (last) closes the frame: ev_txf pulses at its write-back and the next descriptor starts a new 2032-byte allowance. This also holds for a zero-length last descriptor.
- R7: Each consumed descriptor is written back as a first word equal to the fetched one with bit 31 cleared, and ev_txb pulses once for it.
- R8: After a descriptor with flag bit 13 (wrap) set, the next descriptor is at the ring base; otherwise it is at the current pointer + 8.
- R9: Writing the ring base stores the value with its two low bits forced to zero and moves the current pointer to that base.
- R10: The current pointer is kept between walks, so a later kick resumes at the descriptor where the previous walk stopped.
- R11: Every memory request carries a word-aligned address and holds its address until mem_ack is seen.
- R12: A kick that arrives while a walk is in progress has no effect on the walk or on what follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable (control register bit 1) |
| kick | input | 1 | One-cycle pulse: transmit-active register written |
| base_wr | input | 1 | Ring base register write strobe |
| base_data | input | AW | Ring base write value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| fo_valid | output | 1 | Frame byte valid |
| fo_byte | output | 8 | Frame byte |
| ev_txb | output | 1 | Pulse: a descriptor was consumed |
| ev_txf | output | 1 | Pulse: a frame was completed |
| ev_babt | output | 1 | Pulse: a buffer was cut at the frame cap |
| busy | output | 1 | A walk is in progress |

## Verification
Three events can land in the same cycle. When the descriptor that crosses the 2032-byte cap is also the last one of its frame, the buffer-consumed, frame-complete and cap-exceeded pulses all come from one write-back. The bench builds a 2000-byte buffer followed by a 100-byte last buffer. The reference model then expects exactly 32 more bytes and a single event word with all three bits set. Each pulse is compared as a triple in the cycle it appears, so a split or a missing bit shows up as a mismatch.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC0,
    S_DESC1,
    S_DATA,
    S_WBACK
  } txr_state_e;

  localparam int unsigned FLG_READY = 15;
  localparam int unsigned FLG_WRAP  = 13;
  localparam int unsigned FLG_LAST  = 11;
  localparam int unsigned DESC_BYTES = 8;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] base_q, base_nx;
  logic [AW-1:0] ptr_q, ptr_nx;
  logic          upd;

  always_comb begin
    base_nx = base_q;
    ptr_nx  = ptr_q;
    if (adv) begin
      ptr_nx = wrap ? base_q : (ptr_q + AW'(STEP));
    end
    // a base write wins over an advance in the same cycle
    if (base_wr) begin
      base_nx = base_in & ~AW'(3);
      ptr_nx  = base_in & ~AW'(3);
    end
  end

  assign upd = base_wr | adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (upd) begin
      base_q <= base_nx;
      ptr_q  <= ptr_nx;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/txr_frame_cap.sv
module txr_frame_cap #(
  parameter int unsigned CAP = 2032,
  parameter int unsigned LW  = 16,
  parameter int unsigned CW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [LW-1:0] req_len,
  output logic [LW-1:0] eff_len,
  output logic          clip,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [LW-1:0] room;

  assign room    = LW'(CAP) - LW'(cnt_q);
  assign clip    = (req_len > room);
  assign eff_len = clip ? room : req_len;

  always_comb begin
    cnt_nx = cnt_q;
    if (clr) begin
      cnt_nx = '0;
    end else if (inc) begin
      cnt_nx = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr | inc) begin
      cnt_q <= cnt_nx;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine
  import txr_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned FRAME_CAP = 2032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          kick,
  input  logic          base_wr,
  input  logic [AW-1:0] base_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          fo_valid,
  output logic [7:0]    fo_byte,
  output logic          ev_txb,
  output logic          ev_txf,
  output logic          ev_babt,
  output logic          busy
);
  localparam int unsigned LW    = 16;
  localparam int unsigned CNT_W = $clog2(FRAME_CAP + 1);

  txr_state_e    st_q, st_nx;
  logic [LW-1:0] flags_q, flags_nx;
  logic [LW-1:0] len_q, len_nx;
  logic [AW-1:0] bufp_q, bufp_nx;
  logic [LW-1:0] rem_q, rem_nx;
  logic          clip_q, clip_nx;
  logic          fo_valid_q, fo_valid_nx;
  logic [7:0]    fo_byte_q, fo_byte_nx;
  logic          txb_q, txf_q, babt_q;
  logic          txb_nx, txf_nx, babt_nx;

  logic [AW-1:0] ptr;
  logic          start, adv, cnt_clr, cnt_inc;
  logic [LW-1:0] eff_len;
  logic          clip_w;
  logic [CNT_W-1:0] cnt_w;
  logic [7:0]    sel_byte;

  assign start = kick & ctrl_en & (st_q == S_IDLE);
  assign adv   = (st_q == S_WBACK) & mem_ack;

  txr_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) ring_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_wr (base_wr),
    .base_in (base_data),
    .adv     (adv),
    .wrap    (flags_q[FLG_WRAP]),
    .ptr_o   (ptr)
  );

  assign cnt_clr = start | (adv & flags_q[FLG_LAST]);
  assign cnt_inc = (st_q == S_DATA) & mem_ack;

  txr_frame_cap #(.CAP(FRAME_CAP), .LW(LW), .CW(CNT_W)) cap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .req_len (len_q),
    .eff_len (eff_len),
    .clip    (clip_w),
    .cnt_o   (cnt_w)
  );

  // big-endian byte lane pick
  always_comb begin
    case (bufp_q[1:0])
      2'd0:    sel_byte = mem_rdata[31:24];
      2'd1:    sel_byte = mem_rdata[23:16];
      2'd2:    sel_byte = mem_rdata[15:8];
      default: sel_byte = mem_rdata[7:0];
    endcase
  end

  // next-state logic
  always_comb begin
    st_nx       = st_q;
    flags_nx    = flags_q;
    len_nx      = len_q;
    bufp_nx     = bufp_q;
    rem_nx      = rem_q;
    clip_nx     = clip_q;
    fo_valid_nx = 1'b0;
    fo_byte_nx  = fo_byte_q;
    txb_nx      = 1'b0;
    txf_nx      = 1'b0;
    babt_nx     = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) st_nx = S_DESC0;
      end
      S_DESC0: begin
        if (mem_ack) begin
          flags_nx = mem_rdata[31:16];
          len_nx   = mem_rdata[15:0];
          st_nx    = mem_rdata[16 + FLG_READY] ? S_DESC1 : S_IDLE;
        end
      end
      S_DESC1: begin
        if (mem_ack) begin
          bufp_nx = mem_rdata[AW-1:0];
          rem_nx  = eff_len;
          clip_nx = clip_w;
          st_nx   = (eff_len == '0) ? S_WBACK : S_DATA;
        end
      end
      S_DATA: begin
        if (mem_ack) begin
          fo_valid_nx = 1'b1;
          fo_byte_nx  = sel_byte;
          bufp_nx     = bufp_q + AW'(1);
          rem_nx      = rem_q - LW'(1);
          if (rem_q == LW'(1)) st_nx = S_WBACK;
        end
      end
      S_WBACK: begin
        if (mem_ack) begin
          txb_nx  = 1'b1;
          txf_nx  = flags_q[FLG_LAST];
          babt_nx = clip_q;
          st_nx   = S_DESC0;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      flags_q    <= '0;
      len_q      <= '0;
      bufp_q     <= '0;
      rem_q      <= '0;
      clip_q     <= 1'b0;
      fo_valid_q <= 1'b0;
      fo_byte_q  <= '0;
      txb_q      <= 1'b0;
      txf_q      <= 1'b0;
      babt_q     <= 1'b0;
    end else begin
      st_q       <= st_nx;
      fo_valid_q <= fo_valid_nx;
      txb_q      <= txb_nx;
      txf_q      <= txf_nx;
      babt_q     <= babt_nx;
      if (mem_ack) begin
        flags_q   <= flags_nx;
        len_q     <= len_nx;
        bufp_q    <= bufp_nx;
        rem_q     <= rem_nx;
        clip_q    <= clip_nx;
        fo_byte_q <= fo_byte_nx;
      end
    end
  end

  // memory port
  always_comb begin
    mem_addr  = ptr;
    mem_wdata = '0;
    case (st_q)
      S_DESC1: mem_addr = ptr + AW'(4);
      S_DATA:  mem_addr = bufp_q & ~AW'(3);
      S_WBACK: begin
        mem_addr  = ptr;
        mem_wdata = {1'b0, flags_q[LW-2:0], len_q};
      end
      default: mem_addr = ptr;
    endcase
  end

  assign mem_req  = (st_q != S_IDLE);
  assign mem_we   = (st_q == S_WBACK);
  assign busy     = (st_q != S_IDLE);
  assign fo_valid = fo_valid_q;
  assign fo_byte  = fo_byte_q;
  assign ev_txb   = txb_q;
  assign ev_txf   = txf_q;
  assign ev_babt  = babt_q;
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
  parameter int unsigned AW  = 32,
  parameter int unsigned CW  = 11,
  parameter int unsigned CAP = 2032
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_en,
  input logic          kick,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          ev_txb,
  input logic          ev_txf,
  input logic          ev_babt,
  input logic [CW-1:0] frm_cnt
);
  // R11
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R11
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R7
  wback_ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  // R6
  frame_needs_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txf |-> ev_txb);

  // R5
  babble_needs_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_babt |-> ev_txb);

  // R5
  frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_cnt <= CW'(CAP));

  // R2
  kick_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && kick && !ctrl_en) |=> !busy);
endmodule

bind txbd_ring_engine txr_chk #(.AW(AW), .CW(CNT_W), .CAP(FRAME_CAP)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_en   (ctrl_en),
  .kick      (kick),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .ev_txb    (ev_txb),
  .ev_txf    (ev_txf),
  .ev_babt   (ev_babt),
  .frm_cnt   (cnt_w)
);

// File: tb/txbd_ring_engine_tb_top.sv
module txbd_ring_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0;
  logic        kick = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_data = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        fo_valid;
  logic [7:0]  fo_byte;
  logic        ev_txb, ev_txf, ev_babt, busy;

  always #10 clk = ~clk;

  txbd_ring_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .kick(kick),
    .base_wr(base_wr), .base_data(base_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fo_valid(fo_valid), .fo_byte(fo_byte),
    .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt), .busy(busy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R2";

  logic [31:0] mem  [int unsigned];
  logic [31:0] mmem [int unsigned];
  logic [64:0] exp_acc [$];
  logic [7:0]  exp_byte [$];
  logic [2:0]  exp_ev [$];
  logic [31:0] mptr = '0;
  logic [31:0] mbase = '0;

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [31:0] rd(logic [31:0] a, bit model);
    if (model) return mmem.exists(a >> 2) ? mmem[a >> 2] : 32'h0;
    return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
  endfunction

  task automatic poke(logic [31:0] a, logic [31:0] v);
    mem[a >> 2]  = v;
    mmem[a >> 2] = v;
  endtask

  task automatic desc(logic [31:0] a, logic [15:0] fl, logic [15:0] ln, logic [31:0] bp);
    poke(a, {fl, ln});
    poke(a + 4, bp);
  endtask

  task automatic fill(logic [31:0] a0, int nbytes);
    for (int w = 0; w < (nbytes + 7) / 4; w++) begin
      logic [31:0] wa;
      logic [31:0] v;
      wa = (a0 & ~32'h3) + 32'(w * 4);
      for (int b = 0; b < 4; b++) begin
        logic [31:0] ba;
        ba = wa + 32'(b);
        v[31 - 8*b -: 8] = ba[7:0] ^ ba[15:8] ^ 8'h3c;
      end
      poke(wa, v);
    end
  endtask

  // behavioural reference of one walk (R1, R3-R8)
  task automatic model_walk();
    int cnt;
    cnt = 0;
    forever begin
      logic [31:0] w0, w1;
      logic [15:0] fl;
      int ln, room, eff;
      bit clip;
      w0 = rd(mptr, 1);
      exp_acc.push_back({1'b0, mptr, 32'h0});
      fl = w0[31:16];
      if (!fl[15]) break;
      w1 = rd(mptr + 4, 1);
      exp_acc.push_back({1'b0, mptr + 32'd4, 32'h0});
      ln   = int'(w0[15:0]);
      room = 2032 - cnt;
      clip = ln > room;
      eff  = clip ? room : ln;
      for (int i = 0; i < eff; i++) begin
        logic [31:0] a;
        logic [31:0] wv;
        a  = w1 + 32'(i);
        wv = rd(a, 1);
        exp_acc.push_back({1'b0, a & ~32'h3, 32'h0});
        exp_byte.push_back(wv[31 - 8*a[1:0] -: 8]);
        cnt++;
      end
      exp_acc.push_back({1'b1, mptr, {1'b0, w0[30:0]}});
      mmem[mptr >> 2] = {1'b0, w0[30:0]};
      exp_ev.push_back({1'b1, fl[11], clip});
      if (fl[11]) cnt = 0;
      mptr = fl[13] ? mbase : mptr + 32'd8;
    end
  endtask

  // memory responder and per-cycle comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else begin
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (exp_acc.size() == 0) begin
          chk(0, tag, "unexpected memory access", longint'(mem_addr), 0);
        end else begin
          logic [64:0] e;
          e = exp_acc.pop_front();
          chk(mem_addr == e[63:32], tag, "access address", longint'(mem_addr), longint'(e[63:32]));
          chk(mem_we == e[64], tag, "access direction", longint'(mem_we), longint'(e[64]));
          if (e[64]) chk(mem_wdata == e[31:0], {tag, " R7"}, "write-back word",
                         longint'(mem_wdata), longint'(e[31:0]));
        end
        if (mem_we) mem[mem_addr >> 2] = mem_wdata;
        else        mem_rdata = rd(mem_addr, 0);
        mem_ack = 1'b1;
      end
      if (fo_valid) begin
        if (exp_byte.size() == 0) chk(0, {tag, " R4"}, "unexpected byte", longint'(fo_byte), 0);
        else begin
          logic [7:0] eb;
          eb = exp_byte.pop_front();
          chk(fo_byte == eb, {tag, " R4"}, "frame byte", longint'(fo_byte), longint'(eb));
        end
      end
      if (ev_txb | ev_txf | ev_babt) begin
        if (exp_ev.size() == 0) chk(0, {tag, " R6"}, "unexpected event",
                                    longint'({ev_txb, ev_txf, ev_babt}), 0);
        else begin
          logic [2:0] ee;
          ee = exp_ev.pop_front();
          chk({ev_txb, ev_txf, ev_babt} == ee, {tag, " R5 R6 R7"}, "event triple",
              longint'({ev_txb, ev_txf, ev_babt}), longint'(ee));
        end
      end
    end
  end

  task automatic set_base(logic [31:0] v);
    @(negedge clk);
    base_wr = 1'b1;
    base_data = v;
    @(negedge clk);
    base_wr = 1'b0;
    mbase = v & ~32'h3;
    mptr  = mbase;
  endtask

  task automatic pulse_kick();
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(!busy, tag, "walk finished", longint'(busy), 0);
    chk(exp_acc.size() == 0, tag, "accesses left", exp_acc.size(), 0);
    chk(exp_byte.size() == 0, {tag, " R4"}, "bytes left", exp_byte.size(), 0);
    chk(exp_ev.size() == 0, {tag, " R6"}, "events left", exp_ev.size(), 0);
  endtask

  task automatic run(bit kick_again);
    model_walk();
    pulse_kick();
    if (kick_again) begin
      repeat (30) @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
    end
    wait_idle();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    tag = "R2";
    chk({busy, mem_req, fo_valid, ev_txb, ev_txf, ev_babt} == 6'b0, "R2", "reset outputs",
        longint'({busy, mem_req, fo_valid, ev_txb, ev_txf, ev_babt}), 0);

    // R2 kick ignored while disabled
    desc(32'h0, 16'h8800, 16'd2, 32'h2000);
    fill(32'h2000, 8);
    pulse_kick();
    repeat (10) @(negedge clk);
    chk(!busy, "R2", "busy after disabled kick", longint'(busy), 0);
    ctrl_en = 1'b1;

    // R1 R3 R4 R8 R9: multi-buffer frame, zero-length last, stop on not ready
    tag = "R1 R3 R8 R9";
    set_base(32'h1003);
    fill(32'h2001, 16);
    desc(32'h1000, 16'h8000, 16'd3, 32'h2001);
    desc(32'h1008, 16'h8800, 16'd5, 32'h2006);
    desc(32'h1010, 16'h8800, 16'd0, 32'h2400);
    desc(32'h1018, 16'h2800, 16'd2, 32'h2100);
    run(0);
    chk(mem[32'h1000 >> 2] == 32'h00000003, "R7", "ready cleared d0",
        longint'(mem[32'h1000 >> 2]), 32'h3);
    chk(mem[32'h1018 >> 2] == 32'h28000002, "R3", "stopped descriptor untouched",
        longint'(mem[32'h1018 >> 2]), 32'h28000002);

    // R10 resume at stopped descriptor, R8 wrap back to base
    tag = "R10 R8";
    fill(32'h2100, 4);
    desc(32'h1018, 16'hA800, 16'd2, 32'h2100);
    run(0);

    // R9 new base moves pointer
    tag = "R9";
    fill(32'h2200, 8);
    set_base(32'h3002);
    desc(32'h3000, 16'hA800, 16'd4, 32'h2202);
    run(0);

    // R5 cap crossing on a last buffer, R12 kick during walk
    tag = "R5 R12";
    fill(32'h10000, 2104);
    set_base(32'h4000);
    desc(32'h4000, 16'h8000, 16'd2000, 32'h10000);
    desc(32'h4008, 16'h8800, 16'd100, 32'h10000 + 32'd2000);
    desc(32'h4010, 16'h8800, 16'd3, 32'h10100);
    desc(32'h4018, 16'h0000, 16'd0, 32'h0);
    run(1);
    chk(mem[32'h4008 >> 2] == 32'h08000064, "R5", "clipped descriptor write-back",
        longint'(mem[32'h4008 >> 2]), 32'h08000064);

    summary();
    $finish;
  end
endmodule